// File: doc/BRIEF.md
# Funnel Shift Field Extract/Insert Unit

This block is the bit-field datapath of a 32-bit execution unit. It joins a left and a right operand into one 64-bit quantity, takes the 32 bits that start `shift` positions below the top, and keeps only the low `mask` bits of that word. With the insert flag set, bits of the right operand are also merged in wherever the width mask and a second mask built from the shift amount agree. Together these give field extract, field deposit and plain funnel rotates.

A 16-bit descriptor controls the operation. It is held in one of two registers: a stored field register, or a register that latches an immediate value. A select input picks which register controls the operation, so the two field opcodes differ only in where the descriptor comes from. The operand-to-result path is purely combinational. A descriptor whose shift or width is out of range raises an error flag and forces the result to zero.

Top module: `fshift_field_unit`

## Requirements
- R1: After reset, both descriptor registers hold zero, so `result` is 0 and `desc_err` is 0 for any operands.
- R2: With shift 0 and mask 32 and insert clear, `result` equals `left_op`.
- R3: With shift 32 and mask 32 and insert clear, `result` equals `right_op`.
- R4: For shift s in 1..31 with mask 32 and insert clear, `result` is `left_op` moved up by s bits, with its low s bits filled from the top s bits of `right_op`.
- R5: With insert clear, `result` bits at positions of mask width m and above are zero, and the bits below m are the funnel-shifted word, for every s and m in 0..32.
- R6: With insert set, `result` is the masked shifted word ORed with `right_op` at every bit position i where (i < m) equals (i < s).
- R7: Descriptor layout: bits [5:0] are the shift, bits [11:6] are the mask width, and bit 12 is the insert flag. When `use_imm` is 1, the immediate register (loaded from `imm_in` when `imm_we` is 1) controls the operation. When `use_imm` is 0, the field register (loaded from `fld_in` when `fld_we` is 1) controls it.
- R8: Descriptor bits [15:13] have no effect on `result` or `desc_err`.
- R9: A shift above 32 or a mask above 32 sets `desc_err` to 1 and forces `result` to 0. Otherwise `desc_err` is 0.
- R10: A descriptor register changes only at a clock edge where its write enable is 1. The new value controls `result` from that edge on, and changes on `fld_in` or `imm_in` without the enable have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the descriptor registers |
| left_op | input | 32 | Left operand (upper half of the funnel) |
| right_op | input | 32 | Right operand (lower half of the funnel, insert source) |
| fld_we | input | 1 | Load enable for the stored field register |
| fld_in | input | 16 | New field register value |
| imm_we | input | 1 | Load enable for the immediate descriptor register |
| imm_in | input | 16 | Immediate bus value to latch |
| use_imm | input | 1 | 1 selects the immediate register, 0 selects the field register |
| result | output | 32 | Shifted, masked and optionally merged result |
| desc_err | output | 1 | Selected descriptor has shift or mask above 32 |

## Verification
A descriptor write is visible in `result` and `desc_err` from the first clock edge at which the enable is high, with no further delay. Operand and `use_imm` changes reach the outputs in the same cycle, because that path is combinational. The bench therefore drives every input just after a falling edge and samples one time unit after the next rising edge. For operand-only changes it samples a short delay after the new values are applied. Each of the 2178 shift, width and insert combinations is checked against a bit-by-bit reference with two operand patterns.

// File: rtl/fshift_field_unit.sv
module fshift_field_unit #(
  parameter int W      = 32,
  parameter int DESC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      left_op,
  input  logic [W-1:0]      right_op,
  input  logic              fld_we,
  input  logic [DESC_W-1:0] fld_in,
  input  logic              imm_we,
  input  logic [DESC_W-1:0] imm_in,
  input  logic              use_imm,
  output logic [W-1:0]      result,
  output logic              desc_err
);
  localparam int FW = $clog2(W) + 1;
  localparam logic [FW-1:0] WMAX = FW'(W);

  logic [DESC_W-1:0] fld_q, imm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q <= '0;
      imm_q <= '0;
    end else begin
      if (fld_we) fld_q <= fld_in;
      if (imm_we) imm_q <= imm_in;
    end
  end

  wire [DESC_W-1:0] desc  = use_imm ? imm_q : fld_q;
  wire [FW-1:0]     sh_f  = desc[FW-1:0];
  wire [FW-1:0]     mk_f  = desc[2*FW-1:FW];
  wire              ins_f = desc[2*FW];
  logic unused_hi;
  assign unused_hi = ^desc[DESC_W-1:2*FW+1];

  wire [W-1:0]   ones    = '1;
  wire [2*W-1:0] funnel  = {left_op, right_op} << sh_f;
  wire [W-1:0]   shifted = funnel[2*W-1:W];
  wire [W-1:0]   mask_a  = ~(ones << mk_f);
  wire [W-1:0]   mask_b  = ~(ones << sh_f);
  wire [W-1:0]   hole    = ~(mask_a ^ mask_b);
  wire [W-1:0]   merged  = (shifted & mask_a) | (ins_f ? (right_op & hole) : '0);

  assign desc_err = (sh_f > WMAX) || (mk_f > WMAX);
  assign result   = desc_err ? '0 : merged;

  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> result == '0);

  a_r2_left_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_f == '0 && mk_f == WMAX && !ins_f) |-> result == left_op);

  a_r3_right_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_f == WMAX && mk_f == WMAX && !ins_f) |-> result == right_op);

  a_r5_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_err && !ins_f && mk_f < WMAX) |-> (result >> mk_f) == '0);

  a_r10_fld_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_we |=> $stable(fld_q));

  a_r10_imm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_we |=> $stable(imm_q));
endmodule

// File: tb/fshift_field_unit_test.sv
module fshift_field_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] left_op = 0, right_op = 0;
  logic        fld_we = 0, imm_we = 0, use_imm = 0;
  logic [15:0] fld_in = 0, imm_in = 0;
  logic [31:0] result;
  logic        desc_err;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fshift_field_unit uut (.clk(clk), .rst_n(rst_n), .left_op(left_op), .right_op(right_op),
    .fld_we(fld_we), .fld_in(fld_in), .imm_we(imm_we), .imm_in(imm_in),
    .use_imm(use_imm), .result(result), .desc_err(desc_err));

  function automatic logic [31:0] ref_f(input logic [31:0] l, input logic [31:0] r,
                                        input int s, input int m, input bit ins);
    logic [31:0] o = 0;
    if (s > 32 || m > 32) return 0;
    for (int i = 0; i < 32; i++) begin
      logic b = (i < s) ? r[32 - s + i] : l[i - s];
      o[i] = (i < m) ? b : 1'b0;
      if (ins && ((i < m) == (i < s))) o[i] = o[i] | r[i];
    end
    return o;
  endfunction

  function automatic logic [15:0] mk_desc(input int s, input int m, input bit ins);
    return {3'b000, ins, m[5:0], s[5:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_fld(input logic [15:0] d);
    @(negedge clk); fld_in = d; fld_we = 1;
    @(posedge clk); #1; fld_we = 0;
  endtask

  task automatic write_imm(input logic [15:0] d);
    @(negedge clk); imm_in = d; imm_we = 1;
    @(posedge clk); #1; imm_we = 0;
  endtask

  task automatic t_reset;
    left_op = 32'hDEADBEEF; right_op = 32'h12345678;
    #1;
    chk("R1 result", result, 0);
    chk("R1 err", {31'd0, desc_err}, 0);
  endtask

  task automatic t_sweep;
    for (int ins = 0; ins < 2; ins++)
      for (int s = 0; s <= 32; s++)
        for (int m = 0; m <= 32; m++) begin
          string tag;
          tag = (ins == 1) ? "R6" : (m == 32 && s == 0) ? "R2" :
                (m == 32 && s == 32) ? "R3" : (m == 32) ? "R4" : "R5";
          left_op = 32'hA5C3_0F96; right_op = 32'h3C5A_F0E1;
          write_fld(mk_desc(s, m, ins[0]));
          chk(tag, result, ref_f(left_op, right_op, s, m, ins[0]));
          left_op = 32'h8000_0001 ^ (32'(s) << 7); right_op = 32'hFFFF_0000 ^ 32'(m * 977);
          #1;
          chk(tag, result, ref_f(left_op, right_op, s, m, ins[0]));
        end
  endtask

  task automatic t_select;
    left_op = 32'h0123_4567; right_op = 32'h89AB_CDEF;
    write_fld(mk_desc(8, 32, 0));
    write_imm(mk_desc(4, 16, 1));
    use_imm = 0; #1;
    chk("R7 fld sel", result, ref_f(left_op, right_op, 8, 32, 0));
    use_imm = 1; #1;
    chk("R7 imm sel", result, ref_f(left_op, right_op, 4, 16, 1));
    use_imm = 0;
  endtask

  task automatic t_ignore_high;
    left_op = 32'hCAFE_F00D; right_op = 32'h1357_9BDF;
    write_fld(mk_desc(12, 20, 0) | 16'hE000);
    chk("R8 result", result, ref_f(left_op, right_op, 12, 20, 0));
    chk("R8 err", {31'd0, desc_err}, 0);
  endtask

  task automatic t_range;
    left_op = 32'hFFFF_FFFF; right_op = 32'hFFFF_FFFF;
    write_fld(mk_desc(33, 5, 1));
    chk("R9 shift33 err", {31'd0, desc_err}, 1); chk("R9 shift33 res", result, 0);
    write_fld(mk_desc(4, 40, 0));
    chk("R9 mask40 err", {31'd0, desc_err}, 1); chk("R9 mask40 res", result, 0);
    write_fld(mk_desc(63, 63, 1));
    chk("R9 both err", {31'd0, desc_err}, 1); chk("R9 both res", result, 0);
    write_fld(mk_desc(32, 32, 1));
    chk("R9 limit ok", {31'd0, desc_err}, 0);
  endtask

  task automatic t_hold;
    left_op = 32'h7654_3210; right_op = 32'hFEDC_BA98;
    write_fld(mk_desc(16, 32, 0));
    write_imm(mk_desc(0, 8, 0));
    @(negedge clk); fld_in = mk_desc(3, 3, 1); imm_in = mk_desc(40, 1, 0);
    @(posedge clk); #1;
    chk("R10 fld hold", result, ref_f(left_op, right_op, 16, 32, 0));
    use_imm = 1; #1;
    chk("R10 imm hold", result, ref_f(left_op, right_op, 0, 8, 0));
    use_imm = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1;
    t_reset;
    t_sweep;
    t_select;
    t_ignore_high;
    t_range;
    t_hold;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule